// File: doc/BRIEF.md
# USB Function Interrupt Controller

This block gathers the event sources of a USB device function into one 16-bit interrupt status word. The word is read and written as two 8-bit halves. The sources are:

- per-endpoint IN and OUT packet-ready levels;
- an isochronous FIFO overrun/underrun pulse;
- a bus-reset pulse;
- resume and suspend pulses.

Software clears a status bit by writing 1 to it. Two 8-bit enable registers select which status bits can raise the function interrupt. A configuration register holds the global function-interrupt enable and a start-of-frame interrupt enable. Both interrupt outputs are registered, level signals that are synchronous to the system clock.

The status bit positions are fixed and interleaved:

- IN flags for endpoints 0 to 4 are on the even bits 0 to 8.
- OUT flags for endpoints 1 to 4 are on the odd bits 3 to 9.
- Bits 12 to 15 hold the overrun/underrun, bus-reset, resume and suspend flags.

The bus-reset flag can never be masked. A single enable bit covers both suspend and resume. A bus reset returns the status word and both enable registers to their defaults, but leaves the reset flag set.

Software uses the block through a small register port. The read data is combinational on the address. A write takes effect at the next clock edge.

Top module: `usb_fn_irq`

## Requirements
- R1: IN packet-ready for endpoint i (i = 0..4) sets status bit 2*i on every clock edge where it is high. While it stays high, a clear cannot remove the bit.
- R2: OUT packet-ready input j (j = 0..3, serving endpoints 1..4) sets status bit 2*j+3, so it uses bits 3, 5, 7 and 9.
- R3: The overrun/underrun pulse sets status bit 12. The bus-reset pulse sets bit 13, the resume pulse sets bit 14 and the suspend pulse sets bit 15.
- R4: Writing 1 to a status bit clears it: address 0 holds status bits 7..0 and address 1 holds bits 15..8. Writing 0 leaves the bit unchanged. If a set event and a clear hit the same bit in the same cycle, the set wins.
- R5: Status bits 1, 10 and 11 always read 0. Enable-low bit 1 and enable-high bits 2, 3, 5 and 6 always read 0 and ignore writes.
- R6: Enable-low (address 2) bit k enables status bit k. Enable-high (address 3) bits 0, 1 and 4 enable status bits 8, 9 and 12. Enable-high bit 7 enables both status bits 14 and 15.
- R7: Status bit 13 counts as enabled whatever the enable registers hold.
- R8: A bus-reset pulse makes the status word read exactly 0x2000 and clears both enable registers at the same edge. The configuration register keeps its value.
- R9: The function interrupt output goes high one cycle after the global enable (configuration bit 0) is 1 and at least one enabled status bit is 1. Otherwise it is low one cycle later.
- R10: The start-of-frame interrupt output is high for the one cycle that follows a start-of-frame pulse, provided configuration bit 1 was set when the pulse arrived.
- R11: After system reset, every register reads 0 and both interrupt outputs are low.
- R12: Address 4 is the configuration register (bit 0 global enable, bit 1 start-of-frame enable, the other bits read 0). Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational on regAddr) |
| epInReady | input | 5 | IN packet-ready levels, endpoints 0..4 |
| epOutReady | input | 4 | OUT packet-ready levels, endpoints 1..4 |
| isoErrPulse | input | 1 | Isochronous FIFO overrun/underrun event |
| busResetPulse | input | 1 | Bus reset detected |
| resumePulse | input | 1 | Resume signalling detected |
| suspendPulse | input | 1 | Suspend condition detected |
| sofPulse | input | 1 | Start-of-frame packet received |
| fnIrq | output | 1 | Combined function interrupt request |
| sofIrq | output | 1 | Start-of-frame interrupt request |

## Verification
The hardest case to reach is a collision in a single cycle. A clear write lands on a bit whose set source is active in that same cycle, or a bus reset coincides with enable writes and flag clears. Directed steps hold an IN ready level high while clearing its bit. Random stimulus keeps ready levels asserted over many cycles, fires bus resets rarely and writes all eight addresses often, so these overlaps recur throughout the run. A cycle-accurate model in the bench predicts every read value and both interrupt outputs.

// File: rtl/usb_fn_irq_pkg.sv
package usb_fn_irq_pkg;

  localparam int REG_W      = 8;
  localparam int STS_W      = 2 * REG_W;
  localparam int ADDR_W     = 3;
  localparam int NUM_IN_EP  = 5;
  localparam int NUM_OUT_EP = 4;

  // status bit placement (decoded by software, so it is fixed)
  localparam int IN_BASE     = 0;
  localparam int OUT_BASE    = 3;
  localparam int ISO_BIT     = 12;
  localparam int BUSRST_BIT  = 13;
  localparam int RESUME_BIT  = 14;
  localparam int SUSPEND_BIT = 15;

  localparam int EN_HI_SUSRES_BIT = 7;
  localparam int CFG_FN_BIT       = 0;
  localparam int CFG_SOF_BIT      = 1;

  localparam int ADDR_STS_LO = 0;
  localparam int ADDR_STS_HI = 1;
  localparam int ADDR_EN_LO  = 2;
  localparam int ADDR_EN_HI  = 3;
  localparam int ADDR_CFG    = 4;

  localparam logic [STS_W-1:0] STS_VALID   = 16'hF3FD;
  localparam logic [REG_W-1:0] EN_LO_WMASK = 8'hFD;
  localparam logic [REG_W-1:0] EN_HI_WMASK = 8'h93;
  localparam logic [STS_W-1:0] BUSRST_ONLY = STS_W'(1) << BUSRST_BIT;

  typedef enum logic [2:0] {
    SEL_STS_LO = 3'd0,
    SEL_STS_HI = 3'd1,
    SEL_EN_LO  = 3'd2,
    SEL_EN_HI  = 3'd3,
    SEL_CFG    = 3'd4,
    SEL_NONE   = 3'd7
  } regSel_e;

  typedef struct packed {
    logic stsLoW1c;
    logic stsHiW1c;
    logic enLoWr;
    logic enHiWr;
    logic cfgWr;
    logic busRst;
  } ctrlStrobe_t;

endpackage

// File: rtl/usb_fn_irq_ctrl.sv
module usb_fn_irq_ctrl
  import usb_fn_irq_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          regWrEn,
  input  logic [AW-1:0] regAddr,
  input  logic          busResetPulse,
  output ctrlStrobe_t   strobe,
  output regSel_e       rdSel
);

  always_comb begin
    if (regAddr == AW'(ADDR_STS_LO))      rdSel = SEL_STS_LO;
    else if (regAddr == AW'(ADDR_STS_HI)) rdSel = SEL_STS_HI;
    else if (regAddr == AW'(ADDR_EN_LO))  rdSel = SEL_EN_LO;
    else if (regAddr == AW'(ADDR_EN_HI))  rdSel = SEL_EN_HI;
    else if (regAddr == AW'(ADDR_CFG))    rdSel = SEL_CFG;
    else                                  rdSel = SEL_NONE;
  end

  always_comb begin
    strobe          = '0;
    strobe.stsLoW1c = regWrEn && (rdSel == SEL_STS_LO);
    strobe.stsHiW1c = regWrEn && (rdSel == SEL_STS_HI);
    strobe.enLoWr   = regWrEn && (rdSel == SEL_EN_LO);
    strobe.enHiWr   = regWrEn && (rdSel == SEL_EN_HI);
    strobe.cfgWr    = regWrEn && (rdSel == SEL_CFG);
    strobe.busRst   = busResetPulse;
  end

endmodule

// File: rtl/usb_fn_irq_dp.sv
module usb_fn_irq_dp
  import usb_fn_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  regSel_e               rdSel,
  input  logic [REG_W-1:0]      wrData,
  input  logic [NUM_IN_EP-1:0]  epInReady,
  input  logic [NUM_OUT_EP-1:0] epOutReady,
  input  logic                  isoErrPulse,
  input  logic                  resumePulse,
  input  logic                  suspendPulse,
  input  logic                  sofPulse,
  output logic [REG_W-1:0]      rdData,
  output logic                  fnIrq,
  output logic                  sofIrq
);

  logic [STS_W-1:0] statusQ, statusD, setVec, clrVec, effMask;
  logic [REG_W-1:0] enLoQ, enHiQ;
  logic             fnEnQ, sofEnQ;

  // event sources mapped onto the interleaved status layout
  always_comb begin
    setVec = '0;
    for (int i = 0; i < NUM_IN_EP; i++)  setVec[IN_BASE + 2*i]  = epInReady[i];
    for (int j = 0; j < NUM_OUT_EP; j++) setVec[OUT_BASE + 2*j] = epOutReady[j];
    setVec[ISO_BIT]     = isoErrPulse;
    setVec[BUSRST_BIT]  = strobe.busRst;
    setVec[RESUME_BIT]  = resumePulse;
    setVec[SUSPEND_BIT] = suspendPulse;
  end

  assign clrVec = {({REG_W{strobe.stsHiW1c}} & wrData),
                   ({REG_W{strobe.stsLoW1c}} & wrData)};

  // set has priority over a same-cycle clear; bus reset overrides all
  always_comb begin
    if (strobe.busRst) statusD = BUSRST_ONLY;
    else               statusD = ((statusQ & ~clrVec) | setVec) & STS_VALID;
  end

  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= statusD;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.busRst) begin
      enLoQ <= '0;
      enHiQ <= '0;
    end else begin
      if (strobe.enLoWr) enLoQ <= wrData & EN_LO_WMASK;
      if (strobe.enHiWr) enHiQ <= wrData & EN_HI_WMASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fnEnQ  <= 1'b0;
      sofEnQ <= 1'b0;
    end else if (strobe.cfgWr) begin
      fnEnQ  <= wrData[CFG_FN_BIT];
      sofEnQ <= wrData[CFG_SOF_BIT];
    end
  end

  always_comb begin
    effMask              = {enHiQ, enLoQ};
    effMask[RESUME_BIT]  = enHiQ[EN_HI_SUSRES_BIT];
    effMask[SUSPEND_BIT] = enHiQ[EN_HI_SUSRES_BIT];
    effMask[BUSRST_BIT]  = 1'b1;
    effMask              = effMask & STS_VALID;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fnIrq  <= 1'b0;
      sofIrq <= 1'b0;
    end else begin
      fnIrq  <= fnEnQ && (|(statusQ & effMask));
      sofIrq <= sofPulse && sofEnQ;
    end
  end

  always_comb begin
    rdData = '0;
    case (rdSel)
      SEL_STS_LO: rdData = statusQ[REG_W-1:0];
      SEL_STS_HI: rdData = statusQ[STS_W-1:REG_W];
      SEL_EN_LO:  rdData = enLoQ;
      SEL_EN_HI:  rdData = enHiQ;
      SEL_CFG: begin
        rdData[CFG_FN_BIT]  = fnEnQ;
        rdData[CFG_SOF_BIT] = sofEnQ;
      end
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/usb_fn_irq.sv
module usb_fn_irq
  import usb_fn_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [REG_W-1:0]      regWrData,
  output logic [REG_W-1:0]      regRdData,
  input  logic [NUM_IN_EP-1:0]  epInReady,
  input  logic [NUM_OUT_EP-1:0] epOutReady,
  input  logic                  isoErrPulse,
  input  logic                  busResetPulse,
  input  logic                  resumePulse,
  input  logic                  suspendPulse,
  input  logic                  sofPulse,
  output logic                  fnIrq,
  output logic                  sofIrq
);

  ctrlStrobe_t strobe;
  regSel_e     rdSel;

  usb_fn_irq_ctrl #(.AW(ADDR_W)) ctrl_i (
    .regWrEn      (regWrEn),
    .regAddr      (regAddr),
    .busResetPulse(busResetPulse),
    .strobe       (strobe),
    .rdSel        (rdSel)
  );

  usb_fn_irq_dp dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .rdSel       (rdSel),
    .wrData      (regWrData),
    .epInReady   (epInReady),
    .epOutReady  (epOutReady),
    .isoErrPulse (isoErrPulse),
    .resumePulse (resumePulse),
    .suspendPulse(suspendPulse),
    .sofPulse    (sofPulse),
    .rdData      (regRdData),
    .fnIrq       (fnIrq),
    .sofIrq      (sofIrq)
  );

endmodule

// File: rtl/usb_fn_irq_chk.sv
module usb_fn_irq_chk
  import usb_fn_irq_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 regWrEn,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [REG_W-1:0]     regWrData,
  input logic [NUM_IN_EP-1:0] epInReady,
  input logic                 busResetPulse,
  input logic                 suspendPulse,
  input logic                 sofPulse,
  input logic                 fnIrq,
  input logic                 sofIrq,
  input logic [STS_W-1:0]     status,
  input logic [REG_W-1:0]     enLo,
  input logic [REG_W-1:0]     enHi,
  input logic                 fnEn,
  input logic                 sofEn
);

  AST_IN_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (epInReady[0] && !busResetPulse) |=> status[IN_BASE]); // R1

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(ADDR_STS_HI) && regWrData[SUSPEND_BIT-REG_W]
     && !suspendPulse && !busResetPulse) |=> !status[SUSPEND_BIT]); // R4

  AST_BUSRST_DEFAULTS: assert property (@(posedge clk) disable iff (!rstN)
    busResetPulse |=> (status[BUSRST_BIT] && enLo == '0 && enHi == '0)); // R8

  AST_RST_UNMASKED: assert property (@(posedge clk) disable iff (!rstN)
    (fnEn && status[BUSRST_BIT]) |=> fnIrq); // R7

  AST_FN_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !fnEn |=> !fnIrq); // R9

  AST_SOF_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    (sofPulse && sofEn) |=> sofIrq); // R10

  AST_SOF_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    !sofEn |=> !sofIrq); // R10

endmodule

bind usb_fn_irq usb_fn_irq_chk chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .regWrEn      (regWrEn),
  .regAddr      (regAddr),
  .regWrData    (regWrData),
  .epInReady    (epInReady),
  .busResetPulse(busResetPulse),
  .suspendPulse (suspendPulse),
  .sofPulse     (sofPulse),
  .fnIrq        (fnIrq),
  .sofIrq       (sofIrq),
  .status       (dp_i.statusQ),
  .enLo         (dp_i.enLoQ),
  .enHi         (dp_i.enHiQ),
  .fnEn         (dp_i.fnEnQ),
  .sofEn        (dp_i.sofEnQ)
);

// File: tb/usb_fn_irq_tb.sv
`timescale 1ns/10ps
module usb_fn_irq_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [4:0] epInReady = '0;
  logic [3:0] epOutReady = '0;
  logic       isoErrPulse = 1'b0, busResetPulse = 1'b0, resumePulse = 1'b0;
  logic       suspendPulse = 1'b0, sofPulse = 1'b0;
  logic       fnIrq, sofIrq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model state
  logic [15:0] mSts = '0;
  logic [7:0]  mEnLo = '0, mEnHi = '0;
  logic        mFnEn = 1'b0, mSofEn = 1'b0, mFn = 1'b0, mSof = 1'b0;

  always #2.5 clk = ~clk;

  usb_fn_irq dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .epInReady(epInReady),
    .epOutReady(epOutReady), .isoErrPulse(isoErrPulse),
    .busResetPulse(busResetPulse), .resumePulse(resumePulse),
    .suspendPulse(suspendPulse), .sofPulse(sofPulse), .fnIrq(fnIrq),
    .sofIrq(sofIrq)
  );

  function automatic logic [15:0] effOf(logic [7:0] lo, logic [7:0] hi);
    return {hi[7], hi[7], 1'b1, hi[4], 2'b00, hi[1:0], lo[7:2], 1'b0, lo[0]};
  endfunction

  function automatic logic [7:0] modelRead(logic [2:0] a);
    case (a)
      3'd0: return mSts[7:0];
      3'd1: return mSts[15:8];
      3'd2: return mEnLo;
      3'd3: return mEnHi;
      3'd4: return {6'b0, mSofEn, mFnEn};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string readTag(logic [2:0] a);
    case (a)
      3'd0: return "R1";
      3'd1: return "R3";
      3'd2, 3'd3: return "R6";
      default: return "R12";
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic modelUpdate();
    logic [15:0] setV, clrV, nSts;
    setV = '0;
    for (int i = 0; i < 5; i++) setV[2*i] = epInReady[i];
    for (int j = 0; j < 4; j++) setV[2*j+3] = epOutReady[j];
    setV[12] = isoErrPulse; setV[13] = busResetPulse;
    setV[14] = resumePulse; setV[15] = suspendPulse;
    clrV = '0;
    if (regWrEn && regAddr == 3'd0) clrV[7:0]  = regWrData;
    if (regWrEn && regAddr == 3'd1) clrV[15:8] = regWrData;
    nSts = busResetPulse ? 16'h2000 : (((mSts & ~clrV) | setV) & 16'hF3FD);
    mFn  = mFnEn && ((mSts & effOf(mEnLo, mEnHi)) != 0);
    mSof = sofPulse && mSofEn;
    if (busResetPulse) begin
      mEnLo = '0; mEnHi = '0;
    end else begin
      if (regWrEn && regAddr == 3'd2) mEnLo = regWrData & 8'hFD;
      if (regWrEn && regAddr == 3'd3) mEnHi = regWrData & 8'h93;
    end
    if (regWrEn && regAddr == 3'd4) begin
      mFnEn = regWrData[0]; mSofEn = regWrData[1];
    end
    mSts = nSts;
  endtask

  task automatic tick();
    #1;
    check(readTag(regAddr), {8'h00, regRdData}, {8'h00, modelRead(regAddr)});
    check("R9", {15'h0, fnIrq}, {15'h0, mFn});
    check("R10", {15'h0, sofIrq}, {15'h0, mSof});
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
  endtask

  task automatic clearPulses();
    isoErrPulse = 0; busResetPulse = 0; resumePulse = 0;
    suspendPulse = 0; sofPulse = 0; regWrEn = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    tick();
    regWrEn = 0;
  endtask

  task automatic expectReg(logic [2:0] a, logic [7:0] exp, string tag);
    regAddr = a;
    #0.1;
    check(tag, {8'h00, regRdData}, {8'h00, exp});
  endtask

  task automatic expectFn(logic exp, string tag);
    check(tag, {15'h0, fnIrq}, {15'h0, exp});
  endtask

  initial begin
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    // R11 reset state
    expectReg(0, 8'h00, "R11"); expectReg(1, 8'h00, "R11");
    expectReg(2, 8'h00, "R11"); expectReg(4, 8'h00, "R11");
    check("R11", {14'h0, fnIrq, sofIrq}, 16'h0);
    // R1 IN flags on even bits
    epInReady = 5'b10101; tick(); epInReady = '0;
    expectReg(0, 8'h11, "R1"); expectReg(1, 8'h01, "R1");
    // R4 write-one-to-clear, write zero no effect
    wr(0, 8'h01); expectReg(0, 8'h10, "R4");
    wr(0, 8'h00); expectReg(0, 8'h10, "R4");
    // R4 set wins over same-cycle clear
    epInReady[2] = 1; wr(0, 8'h10); epInReady = '0;
    expectReg(0, 8'h10, "R4");
    wr(0, 8'h10); wr(1, 8'h01); expectReg(0, 8'h00, "R4");
    // R2 OUT flags on bits 3,5,7,9
    epOutReady = 4'b1111; tick(); epOutReady = '0;
    expectReg(0, 8'hA8, "R2"); expectReg(1, 8'h02, "R2");
    wr(0, 8'hFF); wr(1, 8'hFF);
    // R5 reserved enable bits
    wr(2, 8'hFF); expectReg(2, 8'hFD, "R5");
    wr(3, 8'hFF); expectReg(3, 8'h93, "R5");
    // R3 event pulses
    isoErrPulse = 1; tick(); clearPulses();
    resumePulse = 1; tick(); clearPulses();
    suspendPulse = 1; tick(); clearPulses();
    expectReg(1, 8'hD0, "R3"); expectReg(0, 8'h00, "R5");
    // R9 global enable
    expectFn(1'b0, "R9");
    wr(4, 8'h01); tick(); expectFn(1'b1, "R9");
    // R6 enable mapping
    wr(3, 8'h00); tick(); expectFn(1'b0, "R6");
    wr(3, 8'h80); tick(); expectFn(1'b1, "R6");
    // R8 bus reset defaults
    busResetPulse = 1; tick(); clearPulses();
    expectReg(1, 8'h20, "R8"); expectReg(0, 8'h00, "R8");
    expectReg(2, 8'h00, "R8"); expectReg(3, 8'h00, "R8");
    expectReg(4, 8'h01, "R8");
    // R7 reset flag unmaskable
    tick(); expectFn(1'b1, "R7");
    wr(1, 8'h20); tick(); expectFn(1'b0, "R4");
    // R10 start of frame
    wr(4, 8'h03);
    sofPulse = 1; tick(); clearPulses();
    check("R10", {15'h0, sofIrq}, 16'h1);
    tick(); check("R10", {15'h0, sofIrq}, 16'h0);
    wr(4, 8'h01);
    sofPulse = 1; tick(); clearPulses();
    check("R10", {15'h0, sofIrq}, 16'h0);
    // R12 unused addresses
    expectReg(5, 8'h00, "R12"); expectReg(6, 8'h00, "R12");
    expectReg(7, 8'h00, "R12");
    // random phase
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(7) == 0) epInReady = 5'($urandom);
      if ($urandom_range(7) == 0) epOutReady = 4'($urandom);
      isoErrPulse   = ($urandom_range(7) == 0);
      resumePulse   = ($urandom_range(7) == 0);
      suspendPulse  = ($urandom_range(7) == 0);
      sofPulse      = ($urandom_range(3) == 0);
      busResetPulse = ($urandom_range(63) == 0);
      regWrEn       = ($urandom_range(2) == 0);
      regAddr       = 3'($urandom);
      regWrData     = 8'($urandom);
      tick();
    end
    clearPulses();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule